// File: doc/BRIEF.md
# Configuration Identity Registers with Power-Up Autoload

This block holds the four identity bytes at the low end of a PCI-style configuration header for a network adapter. The bytes are: revision, programming interface, subclass and class code. The class code and the programming interface are fixed. The revision and the subclass are specific to each adapter. They are filled in from non-volatile storage each time reset is released.

Once reset goes away, the block asks an external serial-EEPROM reader for its contents by raising a start pulse. The reader then delivers bytes as a simple stream:
- the first word is the revision;
- the second word is the subclass;
- the third word is a check byte;
- a done flag marks the end of the stream.

The block adds up the received bytes modulo 256. It keeps the loaded identity only when that sum is zero and the stream was well formed. In every other case it falls back to fixed codes. These cases include a wrong byte count, a reader error, and a reader that stays silent too long.

A combinational byte-addressed read port serves the identity bytes to the configuration-space decoder. A busy flag tells the rest of the adapter when the identity is final.

Top module: `cfgid_regs`

## Requirements
- R1: A read at offset 0x0B returns 0x02 at all times, including during reset and while busy.
- R2: A read at offset 0x09 returns 0x00 at all times.
- R3: A read at any offset other than 0x08 to 0x0B returns 0x00.
- R4: `busy` is 1 during reset and stays 1 until the load finishes. `ee_start` is 1 for exactly the one cycle after the first clock edge following reset release.
- R5: While `busy` is 1, offset 0x08 reads 0x20 and offset 0x0A reads 0x80.
- R6: The stream carries the revision first, then the subclass, then the check byte. When the 8-bit sum of the three bytes is 0 and `ee_done` follows, `busy` drops on the edge that samples `ee_done`. From then on, 0x08 and 0x0A return the loaded revision and subclass.
- R7: When the 8-bit sum of the three bytes is not 0, the load ends with 0x08 reading 0x20 and 0x0A reading 0x80.
- R8: `ee_error` sampled during the load ends the load at once, with the fallback values.
- R9: If `TIMEOUT_CYCLES` consecutive load cycles pass with no `ee_valid`, the load ends with the fallback values. `busy` drops on the edge that samples the last of those cycles.
- R10: `ee_done` after fewer than three words, or after more than three words, ends the load with the fallback values.
- R11: After `busy` drops, further stream activity changes neither `busy` nor the read values until the next reset.
- R12: `ee_done` may come in the same cycle as the third word. That word is counted in the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the load starts when it is released |
| ee_start | output | 1 | One-cycle request to the EEPROM reader |
| ee_valid | input | 1 | A stream byte is present on `ee_word` |
| ee_word | input | 8 | Stream byte |
| ee_done | input | 1 | End of stream (may come with the last byte) |
| ee_error | input | 1 | Reader failure |
| rd_addr | input | 8 | Configuration byte offset |
| rd_data | output | 8 | Byte read at `rd_addr` (combinational) |
| busy | output | 1 | Load and check still in progress |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` set to 16 and the default two identity bytes. At that size, the silent-reader expiry can be checked on its exact edge in a few cycles. The bench runs 256 complete loads over a grid of revision and subclass values, with idle gaps of varied length between words. It cycles through three stream shapes: a separate done cycle, done arriving with the last word, and a corrupted check byte. It also sweeps all 256 read offsets after a good load, and drives short streams, long streams, reader errors and late stream activity. In every case the bench works out the expected bytes from the modular sum it computes itself.

// File: rtl/cfgid_pkg.sv
package cfgid_pkg;

  localparam logic [7:0] CLASS_NETWORK     = 8'h02;
  localparam logic [7:0] PROGIF_NONE       = 8'h00;
  localparam logic [7:0] SUBCLASS_FALLBACK = 8'h80;
  localparam logic [7:0] REVISION_FALLBACK = 8'h20;

  localparam logic [7:0] OFS_REVISION = 8'h08;
  localparam logic [7:0] OFS_PROGIF   = 8'h09;
  localparam logic [7:0] OFS_SUBCLASS = 8'h0A;
  localparam logic [7:0] OFS_CLASS    = 8'h0B;

  typedef enum logic [1:0] {
    LD_ARM     = 2'd0,
    LD_REQ     = 2'd1,
    LD_COLLECT = 2'd2,
    LD_DONE    = 2'd3
  } ld_state_t;

  // modular running sum used by the integrity check
  function automatic logic [7:0] sum8(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  // identity byte lookup for one configuration offset
  function automatic logic [7:0] id_lookup(input logic [7:0] ofs,
                                           input logic [7:0] rev,
                                           input logic [7:0] sub);
    logic [7:0] r;
    case (ofs)
      OFS_REVISION: r = rev;
      OFS_PROGIF:   r = PROGIF_NONE;
      OFS_SUBCLASS: r = sub;
      OFS_CLASS:    r = CLASS_NETWORK;
      default:      r = 8'h00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfgid_timeout.sv
module cfgid_timeout #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] idle_q;

  assign expired = run && !kick && (idle_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             idle_q <= '0;
    else if (!run || kick)  idle_q <= '0;
    else if (!expired)      idle_q <= idle_q + 1'b1;
  end

  assert_expire_only_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> run);

  assert_idle_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= LAST);

endmodule

// File: rtl/cfgid_loader.sv
module cfgid_loader
  import cfgid_pkg::*;
#(
  parameter int DATA_BYTES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ee_valid,
  input  logic [7:0]                 ee_word,
  input  logic                       ee_done,
  input  logic                       ee_error,
  input  logic                       timeout,
  output logic                       ee_start,
  output logic                       collecting,
  output logic                       busy,
  output logic                       finish,
  output logic                       pass,
  output logic [DATA_BYTES-1:0][7:0] shadow
);
  localparam int TOTAL = DATA_BYTES + 1;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] TOTAL_C = CW'(TOTAL);

  ld_state_t   state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [7:0]  sum_q, sum_n;
  logic        overrun_q, overrun_n;
  logic        accept, extra;

  assign collecting = (state_q == LD_COLLECT);
  assign ee_start   = (state_q == LD_REQ);
  assign busy       = (state_q != LD_DONE);

  assign accept    = collecting && ee_valid && (cnt_q < TOTAL_C);
  assign extra     = collecting && ee_valid && (cnt_q == TOTAL_C);
  assign cnt_n     = accept ? cnt_q + 1'b1 : cnt_q;
  assign sum_n     = accept ? sum8(sum_q, ee_word) : sum_q;
  assign overrun_n = overrun_q || extra;

  assign finish = collecting && (ee_done || ee_error || timeout);
  assign pass   = finish && !ee_error && !timeout && !overrun_n
                  && (cnt_n == TOTAL_C) && (sum_n == 8'h00);

  always_comb begin
    state_n = state_q;
    case (state_q)
      LD_ARM:     state_n = LD_REQ;
      LD_REQ:     state_n = LD_COLLECT;
      LD_COLLECT: if (finish) state_n = LD_DONE;
      default:    state_n = LD_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LD_ARM;
      cnt_q     <= '0;
      sum_q     <= '0;
      overrun_q <= 1'b0;
    end else begin
      state_q   <= state_n;
      cnt_q     <= cnt_n;
      sum_q     <= sum_n;
      overrun_q <= overrun_n;
    end
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slot_q <= '0;
      else if (accept && cnt_q == CW'(i))      slot_q <= ee_word;
    end
    assign shadow[i] = slot_q;
  end

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ee_start |=> !ee_start && busy);

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOTAL_C);

  assert_error_fails_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (collecting && ee_error) |-> (finish && !pass));

  assert_overrun_fails_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && overrun_q) |-> !pass);

endmodule

// File: rtl/cfgid_readmux.sv
module cfgid_readmux
  import cfgid_pkg::*;
(
  input  logic [7:0] rd_addr,
  input  logic [7:0] rev,
  input  logic [7:0] sub,
  output logic [7:0] rd_data
);
  assign rd_data = id_lookup(rd_addr, rev, sub);
endmodule

// File: rtl/cfgid_regs.sv
module cfgid_regs
  import cfgid_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int DATA_BYTES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       ee_start,
  input  logic       ee_valid,
  input  logic [7:0] ee_word,
  input  logic       ee_done,
  input  logic       ee_error,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       busy
);
  localparam int REV_SLOT = 0;
  localparam int SUB_SLOT = 1;

  logic                       collecting, finish, pass, timeout;
  logic [DATA_BYTES-1:0][7:0] shadow;
  logic [7:0]                 rev_q, sub_q;

  cfgid_timeout #(.LIMIT(TIMEOUT_CYCLES)) i_timeout (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (collecting),
    .kick    (ee_valid),
    .expired (timeout)
  );

  cfgid_loader #(.DATA_BYTES(DATA_BYTES)) i_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .ee_valid   (ee_valid),
    .ee_word    (ee_word),
    .ee_done    (ee_done),
    .ee_error   (ee_error),
    .timeout    (timeout),
    .ee_start   (ee_start),
    .collecting (collecting),
    .busy       (busy),
    .finish     (finish),
    .pass       (pass),
    .shadow     (shadow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q <= REVISION_FALLBACK;
      sub_q <= SUBCLASS_FALLBACK;
    end else if (finish) begin
      rev_q <= pass ? shadow[REV_SLOT] : REVISION_FALLBACK;
      sub_q <= pass ? shadow[SUB_SLOT] : SUBCLASS_FALLBACK;
    end
  end

  cfgid_readmux i_readmux (
    .rd_addr (rd_addr),
    .rev     (rev_q),
    .sub     (sub_q),
    .rd_data (rd_data)
  );

  assert_class_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == OFS_CLASS) |-> (rd_data == CLASS_NETWORK));

  assert_progif_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == OFS_PROGIF) |-> (rd_data == PROGIF_NONE));

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy);

  assert_fallback_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rev_q == REVISION_FALLBACK && sub_q == SUBCLASS_FALLBACK));

  assert_frozen_after_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!busy && $stable(rev_q) && $stable(sub_q)));

endmodule

// File: tb/test_cfgid_regs.sv
module test_cfgid_regs;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ee_start, ee_valid, ee_done, ee_error, busy;
  logic [7:0] ee_word, rd_addr, rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgid_regs #(.TIMEOUT_CYCLES(TMO), .DATA_BYTES(2)) i_cfgid_regs (
    .clk(clk), .rst_n(rst_n), .ee_start(ee_start), .ee_valid(ee_valid),
    .ee_word(ee_word), .ee_done(ee_done), .ee_error(ee_error),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_byte(input int ofs, input logic [7:0] rev,
                                             input logic [7:0] sub);
    if (ofs == 8)  return rev;
    if (ofs == 10) return sub;
    if (ofs == 11) return 8'h02;
    return 8'h00;
  endfunction

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic check_ids(input string req, input logic [7:0] rev, input logic [7:0] sub);
    logic [7:0] d;
    peek(8'h08, d); chk(req, d, rev);
    peek(8'h0A, d); chk(req, d, sub);
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_load;
    logic [7:0] d;
    ee_valid = 0; ee_done = 0; ee_error = 0; ee_word = 0;
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R4 busy in reset", {7'd0, busy}, 8'd1);
    peek(8'h0B, d); chk("R1 class in reset", d, 8'h02);
    tick(); tick();
    rst_n = 1;
    tick();
    chk("R4 start pulse", {7'd0, ee_start}, 8'd1);
    check_ids("R5 fallback while busy", 8'h20, 8'h80);
    tick();
    chk("R4 start single", {7'd0, ee_start}, 8'd0);
  endtask

  task automatic send(input logic [7:0] w, input bit with_done);
    ee_valid = 1; ee_word = w; ee_done = with_done;
    tick();
    ee_valid = 0; ee_done = 0;
  endtask

  task automatic send_done;
    ee_done = 1;
    tick();
    ee_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected end of run");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rd_addr = 0; ee_valid = 0; ee_done = 0; ee_error = 0; ee_word = 0;

    // R6 / R7 / R12: grid of identity values over three stream shapes
    for (int r = 0; r < 16; r++) begin
      for (int s = 0; s < 16; s++) begin
        logic [7:0] rev, sub, ck;
        int mode;
        bit good;
        rev = 8'(r * 17 + 3);
        sub = 8'(s * 29 + 1);
        mode = (r + s) % 3;
        ck = 8'(256 - ((int'(rev) + int'(sub)) % 256));
        if (mode == 2) ck = ck + 8'(1 + s);
        good = ((int'(rev) + int'(sub) + int'(ck)) % 256) == 0;
        start_load();
        send(rev, 0);
        repeat (r % 4) tick();
        send(sub, 0);
        chk("R4 busy mid load", {7'd0, busy}, 8'd1);
        if (mode == 1) begin
          send(ck, 1);
        end else begin
          send(ck, 0);
          repeat (s % 3) tick();
          chk("R4 busy before done", {7'd0, busy}, 8'd1);
          send_done();
        end
        chk("R6 busy falls", {7'd0, busy}, 8'd0);
        if (good) check_ids(mode == 1 ? "R12 done with last" : "R6 loaded ids", rev, sub);
        else      check_ids("R7 bad checksum fallback", 8'h20, 8'h80);
      end
    end

    // R1 R2 R3: all offsets after a good load
    start_load();
    send(8'h31, 0); send(8'h07, 0); send(8'hC8, 1);
    for (int a = 0; a < 256; a++) begin
      peek(8'(a), d);
      chk(a == 11 ? "R1 class" : (a == 9 ? "R2 progif" : "R3 offset map"),
          d, expect_byte(a, 8'h31, 8'h07));
    end

    // R11: late stream activity ignored
    send(8'h11, 0); send(8'h22, 0); send(8'hCD, 1);
    ee_error = 1; tick(); ee_error = 0;
    chk("R11 busy stays low", {7'd0, busy}, 8'd0);
    check_ids("R11 values frozen", 8'h31, 8'h07);

    // R8: reader error mid stream
    start_load();
    send(8'h44, 0);
    ee_error = 1; tick(); ee_error = 0;
    chk("R8 busy falls on error", {7'd0, busy}, 8'd0);
    check_ids("R8 error fallback", 8'h20, 8'h80);

    // R8: error together with a correct final word
    start_load();
    send(8'h10, 0); send(8'h20, 0);
    ee_error = 1; send(8'hD0, 1); ee_error = 0;
    check_ids("R8 error wins", 8'h20, 8'h80);

    // R10: too few words
    start_load();
    send(8'h05, 0); send(8'hFB, 1);
    chk("R10 short busy", {7'd0, busy}, 8'd0);
    check_ids("R10 short stream", 8'h20, 8'h80);

    // R10: too many words, first three sum to zero
    start_load();
    send(8'h12, 0); send(8'h34, 0); send(8'hBA, 0); send(8'h00, 0); send_done();
    check_ids("R10 long stream", 8'h20, 8'h80);

    // R9: silent reader, exact expiry edge
    start_load();
    repeat (TMO - 1) tick();
    chk("R9 busy before expiry", {7'd0, busy}, 8'd1);
    tick();
    chk("R9 busy at expiry", {7'd0, busy}, 8'd0);
    check_ids("R9 timeout fallback", 8'h20, 8'h80);

    // R9: gap just under the limit still loads
    start_load();
    send(8'h61, 0);
    repeat (TMO - 1) tick();
    send(8'h02, 0); send(8'h9D, 1);
    check_ids("R9 gap under limit", 8'h61, 8'h02);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule